// File: doc/BRIEF.md
# Serial Dataflash Command Sequencer

This block is an SPI master that turns one host request into the complete byte sequence that a page-organised serial flash expects. The host gives a command code and its arguments: a page, block or sector index, a byte offset, a buffer select, a speed select, an erase select and one data byte. The block then picks the opcode, packs the arguments into address bytes using the layout that command needs, and appends dummy bytes where that command calls for them. It drives chip select and shifts each byte over a mode 0 serial link whose clock comes from a divided system clock.

Program, erase, transfer and compare commands start an operation inside the device that runs for a long time. For these, the block raises chip select after the address to start the operation. It then keeps sending status reads until the device reports ready. Read and write commands end with a single data byte in each direction. A resume-from-sleep command holds the bus idle for a programmable recovery time before it reports completion. The host sees a simple handshake: it raises a request while the block is ready, and later receives a one-cycle done pulse together with a result byte and a match flag.

Top module: `dflash_seq`

## Requirements
- R1: Outside a frame, `spi_cs_n` is high and `spi_sck` is low. Before every frame, polling frames included, `spi_cs_n` stays high for at least CS_GAP clock cycles. After reset the block is ready, and `done` is low.
- R2: Bytes go out MSB first in SPI mode 0. MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge. Each SCK high phase lasts HALF_DIV clock cycles.
- R3: A main-page read and a continuous read send the opcode and then three address bytes: page[11:6] in the first byte, {page[5:0], offset[9:8]} in the second, and offset[7:0] in the third.
- R4: A main-page read adds four zero dummy bytes after the address. A continuous read adds one zero dummy byte in fast mode (`req_slow`=0) and none in slow mode.
- R5: Buffer read and buffer write send the opcode, then 0x00, then {6'b0, offset[9:8]}, then offset[7:0]. The buffer read opcode depends on `req_buf2` and `req_slow`. The buffer write opcode depends on `req_buf2`.
- R6: Program-from-buffer, load-to-buffer, page erase and compare send page[11:6], then {page[5:0], 2'b00}, then 0x00. Program selects its opcode from `req_erase` and `req_buf2`. Block erase takes a 9-bit index from `req_arg[8:0]` and sends idx[8:3], then {idx[2:0], 5'b0}, then 0x00.
- R7: Sector erase of sector 10 or 11 sends 0x00, then (sector bit 0) shifted left by 4, then 0x00. Every other sector sends the sector number shifted left by 1, then two zero bytes. The sector number is `req_arg[3:0]`.
- R8: Chip erase sends the four bytes of CHIP_SEQ, most significant byte first, as a single frame with no address.
- R9: For the seven commands that start an internal operation, the block raises chip select after the address. It then repeats two-byte frames {status opcode, 0x00} until bit RDY_BIT of the returned status is 1. The final status byte is returned in `result`.
- R10: For compare, `match` is 1 when bit CMP_BIT of the final status is 0, and 0 otherwise. For every other command `match` is 0.
- R11: Sleep and resume each send only their opcode. After the resume frame, chip select stays high for at least WAKE_CYC cycles before `done`. `result` is 0 for these two commands.
- R12: A request is accepted only while `req_ready` is high. A request raised while the block is busy has no effect. `done` lasts exactly one cycle. Status, ID, page read, continuous read, buffer read and buffer write end with one data byte that carries `req_wdata` out; the byte received in that slot is returned in `result`.
- R13: Command codes on `req_cmd`: 0 status, 1 ID, 2 page read, 3 continuous read, 4 buffer read, 5 buffer write, 6 program from buffer, 7 load page to buffer, 8 page erase, 9 block erase, 10 sector erase, 11 chip erase, 12 compare, 13 sleep, 14 resume. Every opcode is a parameter. A paired opcode holds buffer 2 in bits [15:8] and buffer 1 in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_cmd | input | 4 | Command code |
| req_arg | input | 12 | Page, block or sector index |
| req_offset | input | 10 | Byte offset within a page or buffer |
| req_buf2 | input | 1 | Selects buffer 2 instead of buffer 1 |
| req_slow | input | 1 | Selects the slow-mode read opcode |
| req_erase | input | 1 | Program with built-in erase |
| req_wdata | input | 8 | Byte sent in the data slot |
| req_ready | output | 1 | Block idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Received data byte or final status |
| match | output | 1 | Compare result |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that the host raises `req_valid` only as a strobe, and that the device answers every status poll with a defined byte. With that input, the engine is never started while it is busy, and a completed internal operation always ends on a ready status. The stimulus comes from a device model in the bench that answers each status frame with busy a chosen number of times and then with ready. The same model returns a known byte in every data slot. The bench holds a request on the inputs while a command is running, so the stray request meets only the busy state.

// File: rtl/dflash_pkg.sv
// Shared types for the dataflash command sequencer.
// Assumes: 12-bit page index, 10-bit offset, 9-bit block, 4-bit sector.
package dflash_pkg;

    localparam int PAGE_W = 12;
    localparam int OFFS_W = 10;

    typedef enum logic [3:0] {
        CMD_STATUS, CMD_ID, CMD_PAGE_RD, CMD_CONT_RD, CMD_BUF_RD, CMD_BUF_WR,
        CMD_PROGRAM, CMD_LOAD, CMD_PAGE_ERASE, CMD_BLOCK_ERASE, CMD_SECTOR_ERASE,
        CMD_CHIP_ERASE, CMD_COMPARE, CMD_SLEEP, CMD_RESUME
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GAP, ST_HDR, ST_DATA, ST_POLL_OP, ST_POLL_RD, ST_WAKE, ST_FIN
    } state_e;

    // Commands that end with one data byte in each direction.
    function automatic logic has_data(cmd_e c);
        return c inside {CMD_STATUS, CMD_ID, CMD_PAGE_RD, CMD_CONT_RD, CMD_BUF_RD, CMD_BUF_WR};
    endfunction

    // Commands that start an internal operation and need ready polling.
    function automatic logic runs_internal(cmd_e c);
        return c inside {CMD_PROGRAM, CMD_LOAD, CMD_PAGE_ERASE, CMD_BLOCK_ERASE,
                         CMD_SECTOR_ERASE, CMD_CHIP_ERASE, CMD_COMPARE};
    endfunction

endpackage

// File: rtl/dflash_spi_byte.sv
// Mode 0 byte shifter with its own clock divider.
// Does: shifts one byte out MSB first, samples MISO on each rising SCK edge,
//       and pulses done after the eighth falling edge.
// Assumes: start arrives only while busy is low; tx is valid with start.
module dflash_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0] div;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             tick;

    assign tick = busy && (div == DIV_W'(HALF_DIV - 1));
    assign mosi = sh[7];

    // Divider, SCK phase toggling, and the shift registers for both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            sck  <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh   <= tx;
                busy <= 1'b1;
                div  <= '0;
                bitn <= '0;
                sck  <= 1'b0;
            end else if (busy) begin
                div <= tick ? '0 : div + 1'b1;
                if (tick) begin
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    assert_done_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sck && !busy));
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck) |-> $stable(mosi));

endmodule

// File: rtl/dflash_frame.sv
// Header byte builder.
// Does: for a command and byte index, returns the header byte (opcode,
//       packed address, dummy) and the header length in bytes.
// Assumes: opcode has already been selected; CHIP_SEQ[23:0] is the chip-erase tail.
module dflash_frame
    import dflash_pkg::*;
#(
    parameter logic [31:0] CHIP_SEQ = 32'hC794_809A
) (
    input  cmd_e              cmd,
    input  logic              slow,
    input  logic [PAGE_W-1:0] arg,
    input  logic [OFFS_W-1:0] off,
    input  logic [7:0]        opcode,
    input  logic [2:0]        idx,
    output logic [7:0]        byte_o,
    output logic [3:0]        hdr_len
);

    logic [7:0] a1, a2, a3;

    // Address packing: one layout per command family.
    always_comb begin
        a1 = {2'b00, arg[11:6]};
        a2 = {arg[5:0], 2'b00};
        a3 = 8'h00;
        case (cmd)
            CMD_PAGE_RD, CMD_CONT_RD: begin
                a2 = {arg[5:0], off[9:8]};
                a3 = off[7:0];
            end
            CMD_BUF_RD, CMD_BUF_WR: begin
                a1 = 8'h00;
                a2 = {6'b0, off[9:8]};
                a3 = off[7:0];
            end
            CMD_BLOCK_ERASE: begin
                a1 = {2'b00, arg[8:3]};
                a2 = {arg[2:0], 5'b0};
            end
            CMD_SECTOR_ERASE: begin
                if (arg[3:0] == 4'hA || arg[3:0] == 4'hB) begin
                    a1 = 8'h00;
                    a2 = {3'b000, arg[0], 4'b0000};
                end else begin
                    a1 = {3'b000, arg[3:0], 1'b0};
                    a2 = 8'h00;
                end
            end
            CMD_CHIP_ERASE: begin
                a1 = CHIP_SEQ[23:16];
                a2 = CHIP_SEQ[15:8];
                a3 = CHIP_SEQ[7:0];
            end
            default: ;
        endcase
    end

    // Header length per command, dummy bytes included.
    always_comb begin
        case (cmd)
            CMD_STATUS, CMD_ID, CMD_SLEEP, CMD_RESUME: hdr_len = 4'd1;
            CMD_PAGE_RD:                               hdr_len = 4'd8;
            CMD_CONT_RD:                               hdr_len = slow ? 4'd4 : 4'd5;
            default:                                   hdr_len = 4'd4;
        endcase
    end

    // Byte select; any index past the address is a zero dummy.
    always_comb begin
        case (idx)
            3'd0:    byte_o = opcode;
            3'd1:    byte_o = a1;
            3'd2:    byte_o = a2;
            3'd3:    byte_o = a3;
            default: byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/dflash_seq.sv
// Dataflash command sequencer, top level.
// Does: accepts one request while idle, runs the framed command on the SPI
//       link, polls status for internal operations, and pulses done with
//       the result.
// Assumes: req_valid is sampled only while req_ready is high; the device
//          eventually reports ready.
module dflash_seq
    import dflash_pkg::*;
#(
    parameter int          HALF_DIV     = 2,
    parameter int          CS_GAP       = 2,
    parameter int          WAKE_CYC     = 1750,
    parameter int          RDY_BIT      = 7,
    parameter int          CMP_BIT      = 6,
    parameter logic [7:0]  OP_STATUS    = 8'hD7,
    parameter logic [7:0]  OP_ID        = 8'h9F,
    parameter logic [7:0]  OP_PAGE_RD   = 8'hD2,
    parameter logic [7:0]  OP_CONT_FAST = 8'h0B,
    parameter logic [7:0]  OP_CONT_SLOW = 8'h03,
    parameter logic [15:0] OP_BRD_FAST  = 16'hD6D4,
    parameter logic [15:0] OP_BRD_SLOW  = 16'hD3D1,
    parameter logic [15:0] OP_BWR       = 16'h8784,
    parameter logic [15:0] OP_PROG_ER   = 16'h8683,
    parameter logic [15:0] OP_PROG      = 16'h8988,
    parameter logic [15:0] OP_LOAD      = 16'h5553,
    parameter logic [15:0] OP_CMP       = 16'h6160,
    parameter logic [7:0]  OP_PG_ERASE  = 8'h81,
    parameter logic [7:0]  OP_BLK_ERASE = 8'h50,
    parameter logic [7:0]  OP_SEC_ERASE = 8'h7C,
    parameter logic [31:0] CHIP_SEQ     = 32'hC794_809A,
    parameter logic [7:0]  OP_SLEEP     = 8'hB9,
    parameter logic [7:0]  OP_RESUME    = 8'hAB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [3:0]  req_cmd,
    input  logic [11:0] req_arg,
    input  logic [9:0]  req_offset,
    input  logic        req_buf2,
    input  logic        req_slow,
    input  logic        req_erase,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  result,
    output logic        match,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int CNT_MAX = (WAKE_CYC > CS_GAP) ? WAKE_CYC : CS_GAP;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    state_e             st, after;
    cmd_e               c_cmd;
    logic [PAGE_W-1:0]  c_arg;
    logic [OFFS_W-1:0]  c_off;
    logic               c_buf2, c_slow, c_erase;
    logic [7:0]         c_wd;
    logic [2:0]         idx;
    logic [CNT_W-1:0]   cnt;
    logic               kick;
    logic [7:0]         opcode, hdr_byte, tx;
    logic [3:0]         hdr_len;
    logic               eng_busy, eng_done;
    logic [7:0]         eng_rx;
    logic               last_hdr;

    // Opcode choice from the captured command and its select bits.
    always_comb begin
        case (c_cmd)
            CMD_STATUS:       opcode = OP_STATUS;
            CMD_ID:           opcode = OP_ID;
            CMD_PAGE_RD:      opcode = OP_PAGE_RD;
            CMD_CONT_RD:      opcode = c_slow ? OP_CONT_SLOW : OP_CONT_FAST;
            CMD_BUF_RD:       opcode = c_slow ? (c_buf2 ? OP_BRD_SLOW[15:8] : OP_BRD_SLOW[7:0])
                                              : (c_buf2 ? OP_BRD_FAST[15:8] : OP_BRD_FAST[7:0]);
            CMD_BUF_WR:       opcode = c_buf2 ? OP_BWR[15:8] : OP_BWR[7:0];
            CMD_PROGRAM:      opcode = c_erase ? (c_buf2 ? OP_PROG_ER[15:8] : OP_PROG_ER[7:0])
                                               : (c_buf2 ? OP_PROG[15:8] : OP_PROG[7:0]);
            CMD_LOAD:         opcode = c_buf2 ? OP_LOAD[15:8] : OP_LOAD[7:0];
            CMD_PAGE_ERASE:   opcode = OP_PG_ERASE;
            CMD_BLOCK_ERASE:  opcode = OP_BLK_ERASE;
            CMD_SECTOR_ERASE: opcode = OP_SEC_ERASE;
            CMD_CHIP_ERASE:   opcode = CHIP_SEQ[31:24];
            CMD_COMPARE:      opcode = c_buf2 ? OP_CMP[15:8] : OP_CMP[7:0];
            CMD_SLEEP:        opcode = OP_SLEEP;
            default:          opcode = OP_RESUME;
        endcase
    end

    dflash_frame #(.CHIP_SEQ(CHIP_SEQ)) frame_i (
        .cmd(c_cmd), .slow(c_slow), .arg(c_arg), .off(c_off), .opcode(opcode),
        .idx(idx), .byte_o(hdr_byte), .hdr_len(hdr_len)
    );

    // Byte offered to the shifter in each sending state.
    always_comb begin
        case (st)
            ST_DATA:    tx = c_wd;
            ST_POLL_OP: tx = OP_STATUS;
            ST_POLL_RD: tx = 8'h00;
            default:    tx = hdr_byte;
        endcase
    end

    dflash_spi_byte #(.HALF_DIV(HALF_DIV)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(kick), .tx(tx), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx)
    );

    assign last_hdr  = ({1'b0, idx} == hdr_len - 4'd1);
    assign req_ready = (st == ST_IDLE);
    assign done      = (st == ST_FIN);
    assign spi_cs_n  = !(st inside {ST_HDR, ST_DATA, ST_POLL_OP, ST_POLL_RD});

    // Command sequencing: gap, header, data or poll loop, wake hold, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            after   <= ST_HDR;
            c_cmd   <= CMD_STATUS;
            c_arg   <= '0;
            c_off   <= '0;
            c_buf2  <= 1'b0;
            c_slow  <= 1'b0;
            c_erase <= 1'b0;
            c_wd    <= '0;
            idx     <= '0;
            cnt     <= '0;
            kick    <= 1'b0;
            result  <= '0;
            match   <= 1'b0;
        end else begin
            kick <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    c_cmd   <= cmd_e'(req_cmd);
                    c_arg   <= req_arg;
                    c_off   <= req_offset;
                    c_buf2  <= req_buf2;
                    c_slow  <= req_slow;
                    c_erase <= req_erase;
                    c_wd    <= req_wdata;
                    result  <= '0;
                    match   <= 1'b0;
                    idx     <= '0;
                    cnt     <= '0;
                    after   <= ST_HDR;
                    st      <= ST_GAP;
                end
                ST_GAP: if (cnt == CNT_W'(CS_GAP - 1)) begin
                    st   <= after;
                    kick <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_HDR: if (eng_done) begin
                    if (!last_hdr) begin
                        idx  <= idx + 1'b1;
                        kick <= 1'b1;
                    end else if (has_data(c_cmd)) begin
                        st   <= ST_DATA;
                        kick <= 1'b1;
                    end else if (runs_internal(c_cmd)) begin
                        st    <= ST_GAP;
                        after <= ST_POLL_OP;
                        cnt   <= '0;
                    end else if (c_cmd == CMD_RESUME) begin
                        st  <= ST_WAKE;
                        cnt <= '0;
                    end else begin
                        st <= ST_FIN;
                    end
                end
                ST_DATA: if (eng_done) begin
                    result <= eng_rx;
                    st     <= ST_FIN;
                end
                ST_POLL_OP: if (eng_done) begin
                    st   <= ST_POLL_RD;
                    kick <= 1'b1;
                end
                ST_POLL_RD: if (eng_done) begin
                    result <= eng_rx;
                    match  <= (c_cmd == CMD_COMPARE) && !eng_rx[CMP_BIT];
                    if (eng_rx[RDY_BIT]) begin
                        st <= ST_FIN;
                    end else begin
                        st    <= ST_GAP;
                        after <= ST_POLL_OP;
                        cnt   <= '0;
                    end
                end
                ST_WAKE: if (cnt == CNT_W'(WAKE_CYC - 1)) begin
                    st <= ST_FIN;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_idle_sck_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_accept_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> spi_cs_n);
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && spi_cs_n));
    assert_poll_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && runs_internal(c_cmd)) |-> result[RDY_BIT]);
    assert_match_only_cmp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_cmd != CMD_COMPARE) |-> !match);
    assert_kick_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !eng_busy);

endmodule

// File: tb/dflash_seq_tb.sv
// Bench: device model on the SPI pins, per-clock protocol monitor,
// expected frames built from the requirements.
module dflash_seq_tb_top;
    import dflash_pkg::*;

    localparam int CLK_P  = 10;
    localparam int HALF   = 2;
    localparam int GAP    = 3;
    localparam int WAKE   = 40;
    localparam logic [7:0]  T_ST = 8'hD7, T_ID = 8'h9F, T_PRD = 8'hD2, T_CF = 8'h0B, T_CS = 8'h03;
    localparam logic [15:0] T_BRF = 16'hD6D4, T_BRS = 16'hD3D1, T_BW = 16'h8784;
    localparam logic [15:0] T_PE = 16'h8683, T_PN = 16'h8988, T_LD = 16'h5553, T_CMP = 16'h6160;
    localparam logic [7:0]  T_PG = 8'h81, T_BLK = 8'h50, T_SEC = 8'h7C, T_SLP = 8'hB9, T_RES = 8'hAB;
    localparam logic [31:0] T_CHIP = 32'hC794_809A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_buf2 = 1'b0, req_slow = 1'b0, req_erase = 1'b0;
    logic [3:0] req_cmd = '0;
    logic [11:0] req_arg = '0;
    logic [9:0] req_offset = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, done, match, spi_sck, spi_cs_n, spi_mosi, spi_miso;
    logic [7:0] result;

    always #(CLK_P/2) clk = ~clk;

    dflash_seq #(
        .HALF_DIV(HALF), .CS_GAP(GAP), .WAKE_CYC(WAKE), .RDY_BIT(7), .CMP_BIT(6),
        .OP_STATUS(T_ST), .OP_ID(T_ID), .OP_PAGE_RD(T_PRD), .OP_CONT_FAST(T_CF),
        .OP_CONT_SLOW(T_CS), .OP_BRD_FAST(T_BRF), .OP_BRD_SLOW(T_BRS), .OP_BWR(T_BW),
        .OP_PROG_ER(T_PE), .OP_PROG(T_PN), .OP_LOAD(T_LD), .OP_CMP(T_CMP),
        .OP_PG_ERASE(T_PG), .OP_BLK_ERASE(T_BLK), .OP_SEC_ERASE(T_SEC),
        .CHIP_SEQ(T_CHIP), .OP_SLEEP(T_SLP), .OP_RESUME(T_RES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_arg(req_arg), .req_offset(req_offset), .req_buf2(req_buf2),
        .req_slow(req_slow), .req_erase(req_erase), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .result(result), .match(match),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0;

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // Device model: records frames, answers status polls and data slots.
    logic [7:0] s_in = '0, s_out = '0, s_first = '0;
    int s_bits = 0, s_k = 0, busy_left = 0;
    bit s_in_frame = 0, cmp_cfg = 0;
    logic [7:0] got_b[$];
    int got_len[$];
    int partial = 0;

    assign spi_miso = s_out[7];

    function automatic logic [7:0] dev_resp(int k);
        if (s_first == T_ST && k == 1) begin
            if (busy_left > 0) begin
                busy_left--;
                return {1'b0, cmp_cfg, 6'h0B};
            end
            return {1'b1, cmp_cfg, 6'h0B};
        end
        return 8'hC3 + 8'(k);
    endfunction

    always @(negedge spi_cs_n) begin
        s_in_frame = 1; s_bits = 0; s_k = 0; s_out = 8'h00;
    end
    always @(posedge spi_cs_n) if (s_in_frame) begin
        s_in_frame = 0;
        got_len.push_back(s_k);
        if (s_bits != 0) partial++;
    end
    always @(posedge spi_sck) if (spi_cs_n == 1'b0) begin
        s_in = {s_in[6:0], spi_mosi};
        s_bits++;
        if (s_bits == 8) begin
            got_b.push_back(s_in);
            if (s_k == 0) s_first = s_in;
            s_k++;
            s_bits = 0;
        end
    end
    always @(negedge spi_sck) if (spi_cs_n == 1'b0) begin
        if (s_bits == 0) s_out = dev_resp(s_k);
        else s_out = s_out << 1;
    end

    // Per-clock monitor: cs/sck idle levels, gap lengths, SCK phase, busy.
    int hi_run = 0, sck_run = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;
    bit mbusy = 0;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n && spi_sck) chk(0, "R1", "sck high outside frame", 1, 0);
        if (prev_cs && !spi_cs_n) begin
            chk(hi_run >= GAP, "R1", "cs high gap", hi_run, GAP);
            hi_run = 0;
        end
        if (spi_cs_n) hi_run++;
        if (prev_sck && !spi_sck) begin
            chk(sck_run == HALF, "R2", "sck high phase", sck_run, HALF);
            sck_run = 0;
        end
        if (spi_sck) sck_run++;
        if (mbusy && req_ready) chk(0, "R12", "ready while busy", 1, 0);
        prev_cs = spi_cs_n;
        prev_sck = spi_sck;
    end

    // Expected frame store.
    logic [7:0] exp_b[$];
    int exp_len[$];
    int cur = 0;
    task automatic put(logic [7:0] b); exp_b.push_back(b); cur++; endtask
    task automatic close_frame(); exp_len.push_back(cur); cur = 0; endtask

    task automatic run(cmd_e c, int arg, int off, bit b2, bit slow, bit er,
                       logic [7:0] wd, int polls_busy, bit cmpb, string req);
        logic [7:0] exp_res;
        bit exp_match, intern, data;
        int hdr;
        int t;
        intern = c inside {CMD_PROGRAM, CMD_LOAD, CMD_PAGE_ERASE, CMD_BLOCK_ERASE,
                           CMD_SECTOR_ERASE, CMD_CHIP_ERASE, CMD_COMPARE};
        data = c inside {CMD_STATUS, CMD_ID, CMD_PAGE_RD, CMD_CONT_RD, CMD_BUF_RD, CMD_BUF_WR};
        exp_b.delete(); exp_len.delete(); got_b.delete(); got_len.delete(); cur = 0;
        case (c)
            CMD_STATUS: put(T_ST);
            CMD_ID: put(T_ID);
            CMD_PAGE_RD, CMD_CONT_RD: begin
                put(c == CMD_PAGE_RD ? T_PRD : (slow ? T_CS : T_CF));
                put(8'(arg >> 6)); put(8'((arg << 2) | (off >> 8))); put(8'(off & 255));
                if (c == CMD_PAGE_RD) repeat (4) put(8'h00);
                else if (!slow) put(8'h00);
            end
            CMD_BUF_RD, CMD_BUF_WR: begin
                if (c == CMD_BUF_WR) put(b2 ? T_BW[15:8] : T_BW[7:0]);
                else if (slow) put(b2 ? T_BRS[15:8] : T_BRS[7:0]);
                else put(b2 ? T_BRF[15:8] : T_BRF[7:0]);
                put(8'h00); put(8'(off >> 8)); put(8'(off & 255));
            end
            CMD_PROGRAM, CMD_LOAD, CMD_PAGE_ERASE, CMD_COMPARE: begin
                if (c == CMD_PROGRAM) put(er ? (b2 ? T_PE[15:8] : T_PE[7:0]) : (b2 ? T_PN[15:8] : T_PN[7:0]));
                else if (c == CMD_LOAD) put(b2 ? T_LD[15:8] : T_LD[7:0]);
                else if (c == CMD_COMPARE) put(b2 ? T_CMP[15:8] : T_CMP[7:0]);
                else put(T_PG);
                put(8'(arg >> 6)); put(8'(arg << 2)); put(8'h00);
            end
            CMD_BLOCK_ERASE: begin put(T_BLK); put(8'(arg >> 3)); put(8'(arg << 5)); put(8'h00); end
            CMD_SECTOR_ERASE: begin
                put(T_SEC);
                if (arg == 10 || arg == 11) begin put(8'h00); put(8'((arg & 1) << 4)); end
                else begin put(8'(arg << 1)); put(8'h00); end
                put(8'h00);
            end
            CMD_CHIP_ERASE: begin put(8'hC7); put(8'h94); put(8'h80); put(8'h9A); end
            CMD_SLEEP: put(T_SLP);
            default: put(T_RES);
        endcase
        hdr = cur;
        if (data) put(wd);
        close_frame();
        if (intern) repeat (polls_busy + 1) begin put(T_ST); put(8'h00); close_frame(); end
        if (data && c != CMD_STATUS) exp_res = 8'hC3 + 8'(hdr);
        else if (intern || c == CMD_STATUS) exp_res = {1'b1, cmpb, 6'h0B};
        else exp_res = 8'h00;
        exp_match = (c == CMD_COMPARE) && !cmpb;

        busy_left = (c == CMD_STATUS) ? 0 : polls_busy;
        cmp_cfg = cmpb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_cmd = c; req_arg = 12'(arg); req_offset = 10'(off);
        req_buf2 = b2; req_slow = slow; req_erase = er; req_wdata = wd;
        @(posedge clk);
        mbusy = 1;
        @(negedge clk);
        req_cmd = CMD_CHIP_ERASE; req_arg = 12'hFFF; req_wdata = 8'h11;   // stray request, R12
        repeat (3) @(negedge clk);
        req_valid = 0;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        mbusy = 0;
        chk(done, req, "done seen", done, 1);
        chk(result == exp_res, req, "result", result, exp_res);
        chk(match == exp_match, "R10", "match", match, exp_match);
        if (c == CMD_RESUME) chk(hi_run >= WAKE, "R11", "wake hold", hi_run, WAKE);
        @(negedge clk);
        chk(!done, "R12", "done one cycle", done, 0);
        chk(got_len.size() == exp_len.size(), req, "frame count", got_len.size(), exp_len.size());
        chk(got_b.size() == exp_b.size(), req, "byte count", got_b.size(), exp_b.size());
        for (int i = 0; i < exp_len.size() && i < got_len.size(); i++)
            chk(got_len[i] == exp_len[i], req, $sformatf("frame %0d length", i), got_len[i], exp_len[i]);
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
            chk(got_b[i] == exp_b[i], req, $sformatf("byte %0d", i), got_b[i], exp_b[i]);
        chk(partial == 0, "R2", "whole bytes per frame", partial, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(spi_cs_n == 1, "R1", "reset cs_n", spi_cs_n, 1);
        chk(spi_sck == 0, "R1", "reset sck", spi_sck, 0);
        chk(req_ready == 1 && done == 0, "R1", "reset ready/done", {req_ready, done}, 2);
        run(CMD_STATUS, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R12");
        run(CMD_ID, 0, 0, 0, 0, 0, 8'hFF, 0, 0, "R12");
        run(CMD_PAGE_RD, 12'hFFF, 10'h3FF, 0, 0, 0, 8'h5E, 0, 0, "R3");
        run(CMD_PAGE_RD, 12'h123, 10'h2A5, 0, 0, 0, 8'h01, 0, 0, "R4");
        run(CMD_CONT_RD, 12'h801, 10'h155, 0, 0, 0, 8'hA0, 0, 0, "R4");
        run(CMD_CONT_RD, 12'h03F, 10'h300, 0, 1, 0, 8'h0F, 0, 0, "R4");
        run(CMD_BUF_RD, 0, 10'h2C7, 0, 0, 0, 8'h00, 0, 0, "R5");
        run(CMD_BUF_RD, 0, 10'h1FE, 1, 1, 0, 8'h00, 0, 0, "R5");
        run(CMD_BUF_WR, 0, 10'h3A1, 1, 0, 0, 8'h6D, 0, 0, "R5");
        run(CMD_PROGRAM, 12'hABC, 0, 0, 0, 1, 8'h00, 3, 1, "R9");
        run(CMD_PROGRAM, 12'h001, 0, 1, 0, 0, 8'h00, 0, 1, "R6");
        run(CMD_LOAD, 12'h7C0, 0, 1, 0, 0, 8'h00, 1, 1, "R6");
        run(CMD_PAGE_ERASE, 12'h555, 0, 0, 0, 0, 8'h00, 2, 1, "R6");
        run(CMD_BLOCK_ERASE, 12'h1FF, 0, 0, 0, 0, 8'h00, 1, 1, "R6");
        run(CMD_SECTOR_ERASE, 10, 0, 0, 0, 0, 8'h00, 0, 1, "R7");
        run(CMD_SECTOR_ERASE, 11, 0, 0, 0, 0, 8'h00, 0, 1, "R7");
        run(CMD_SECTOR_ERASE, 5, 0, 0, 0, 0, 8'h00, 1, 1, "R7");
        run(CMD_CHIP_ERASE, 0, 0, 0, 0, 0, 8'h00, 4, 1, "R8");
        run(CMD_COMPARE, 12'h2D4, 0, 0, 0, 0, 8'h00, 2, 0, "R10");
        run(CMD_COMPARE, 12'h2D4, 0, 1, 0, 0, 8'h00, 0, 1, "R10");
        run(CMD_SLEEP, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R11");
        run(CMD_RESUME, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R11");
        run(CMD_STATUS, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R13");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule